// File: doc/BRIEF.md
# RS485 Serial Transmitter with Idle Guard

This block is the transmit half of an asynchronous serial port that can also steer the enable pin of an RS485 line driver. Bytes come in over a valid/ready stream into a one-entry holding stage. From there they move into a shift engine, which sends each one as a start bit, eight data bits, an optional parity bit and a stop bit. An external one-cycle baud tick sets the bit period. A programmable guard count adds idle bit periods, with the line held high, after every stop bit.

In RS485 mode the driver-enable output is high whenever the transmitter holds or sends anything, and that includes the guard periods. The bus therefore stays driven until the last guard bit has ended. In normal mode the enable stays low. The transmitter-empty status is high only when the holding stage and the shift engine are both empty.

Back-pressure works as follows. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while the holding stage is full. It rises again when the shift engine takes the byte, which happens on a baud tick that starts the byte's start bit. While `in_ready` is low, `in_valid` and `in_data` are ignored. A source may drop `in_valid` at any time.

Top module: `rs485_tx_guard`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1, `in_ready` is 1 and `drv_en` is 0. Whenever `tx_empty` is 1, `txd` is 1.
- R2: Each character is sent in this order: a start bit of 0, then data bits 0 to 7 with the least significant bit first, then the parity bit if one is enabled, then a stop bit of 1. Each bit lasts exactly one baud-tick period.
- R3: `parity_sel` selects the parity. 2'b01 is even parity, so the parity bit is the XOR of the 8 data bits. 2'b10 is odd parity, so the parity bit is the inverse of that XOR. 2'b00 and 2'b11 send no parity bit.
- R4: After each stop bit, `guard_len` idle bit periods with `txd` at 1 follow. Only after them does the next start bit go out, or `tx_empty` rise.
- R5: When `guard_len` is 0, a pending byte's start bit begins at the baud tick that ends the stop bit. If no byte is pending, `tx_empty` rises right after that tick.
- R6: `in_ready` is low while a byte is held and not yet taken by the shift engine. A write made while `in_ready` is low is ignored and produces no character.
- R7: `tx_empty` goes low on the clock edge that accepts a byte. It stays low until the final stop bit or guard bit has ended.
- R8: When `mode` is 2'b01, `drv_en` is the inverse of `tx_empty`. For any other `mode` value, `drv_en` is 0.
- R9: `txd` changes only right after a clock edge at which `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| mode | input | 2 | 2'b01 selects RS485 driver control; other values select normal mode |
| parity_sel | input | 2 | 01 even, 10 odd, 00/11 none |
| guard_len | input | 8 | Number of idle bit periods after each stop bit |
| in_valid | input | 1 | Source offers a byte |
| in_ready | output | 1 | Holding stage can accept a byte |
| in_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line, idle high |
| tx_empty | output | 1 | Nothing held and nothing being shifted |
| drv_en | output | 1 | RS485 line-driver enable |

## Verification
A bad engine state shows up on `txd` within one bit period. A bit that is missing, repeated or misplaced moves every later sample of the frame, and the sweep samples each bit in the middle of its period. A guard counter that ends early or late changes the time at which `tx_empty` rises, or the time at which the next start bit falls, by at least one baud period. The bench checks both events to the exact bit boundary for guard lengths of 0, 1, 2 and 4. A holding stage that loses or overwrites a byte shows up as a wrong second character in the back-to-back runs, or as an extra character in those runs.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_GUARD
  } tx_state_e;

  localparam logic [1:0] MODE_DRIVER = 2'b01;
  localparam logic [1:0] PAR_EVEN    = 2'b01;
  localparam logic [1:0] PAR_ODD     = 2'b10;
endpackage

// File: rtl/txg_hold_stage.sv
module txg_hold_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);
  assign in_ready = !hold_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (in_valid && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= in_data;
    end
  end

  // A held byte is neither lost nor overwritten until the engine takes it.
  assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take) |=> (hold_full && hold_data == $past(hold_data)));
endmodule

// File: rtl/txg_shift_engine.sv
module txg_shift_engine
  import rs485_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic               hold_full,
  input  logic [DATA_W-1:0]  hold_data,
  input  logic [1:0]         parity_sel,
  input  logic [GUARD_W-1:0] guard_len,
  output logic               take,
  output logic               txd,
  output logic               idle
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e           state;
  logic [DATA_W-1:0]   shreg;
  logic [IDX_W-1:0]    bit_idx;
  logic [GUARD_W-1:0]  gcnt;
  logic                par_en;
  logic                par_bit;
  logic                finish;

  assign finish = baud_tick &&
                  (((state == ST_STOP) && (guard_len == '0)) ||
                   ((state == ST_GUARD) && (gcnt == guard_len)));
  assign take   = hold_full && baud_tick && ((state == ST_IDLE) || finish);
  assign idle   = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      gcnt    <= '0;
      par_en  <= 1'b0;
      par_bit <= 1'b0;
    end else if (take) begin
      state   <= ST_START;
      shreg   <= hold_data;
      par_en  <= (parity_sel == PAR_EVEN) || (parity_sel == PAR_ODD);
      par_bit <= (^hold_data) ^ (parity_sel == PAR_ODD);
    end else if (baud_tick) begin
      case (state)
        ST_START: begin
          state   <= ST_DATA;
          bit_idx <= '0;
        end
        ST_DATA: begin
          if (bit_idx == LAST_IDX) state <= par_en ? ST_PAR : ST_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end
        ST_PAR: state <= ST_STOP;
        ST_STOP: begin
          if (guard_len == '0) state <= ST_IDLE;
          else begin
            state <= ST_GUARD;
            gcnt  <= GUARD_W'(1);
          end
        end
        ST_GUARD: begin
          if (gcnt == guard_len) state <= ST_IDLE;
          else gcnt <= gcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[bit_idx];
      ST_PAR:   txd = par_bit;
      default:  txd = 1'b1;
    endcase
  end

  // With no guard and nothing pending, the engine idles right after the stop bit.
  assert_zero_guard_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && baud_tick && guard_len == '0 && !hold_full) |=> (state == ST_IDLE));

  // A guard period always begins with a count of one.
  assert_guard_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_STOP && state == ST_GUARD) |-> (gcnt == GUARD_W'(1)));
endmodule

// File: rtl/rs485_tx_guard.sv
module rs485_tx_guard
  import rs485_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int GUARD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               baud_tick,
  input  logic [1:0]         mode,
  input  logic [1:0]         parity_sel,
  input  logic [GUARD_W-1:0] guard_len,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  output logic               txd,
  output logic               tx_empty,
  output logic               drv_en
);
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              eng_idle;

  txg_hold_stage #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .take      (take),
    .hold_full (hold_full),
    .hold_data (hold_data)
  );

  txg_shift_engine #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .hold_full  (hold_full),
    .hold_data  (hold_data),
    .parity_sel (parity_sel),
    .guard_len  (guard_len),
    .take       (take),
    .txd        (txd),
    .idle       (eng_idle)
  );

  assign tx_empty = eng_idle && !hold_full;
  assign drv_en   = (mode == MODE_DRIVER) && !tx_empty;

  // The line only moves on a baud tick.
  assert_txd_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(baud_tick));

  // A low line means a character is in flight.
  assert_low_line_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> !tx_empty);

  // An empty transmitter leaves the line idle high.
  assert_empty_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);
endmodule

// File: tb/sim_rs485_tx_guard.sv
module sim_rs485_tx_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] parity_sel = 2'b00;
  logic [7:0] guard_len = 8'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       txd;
  logic       tx_empty;
  logic       drv_en;

  int checks = 0;
  int failures = 0;
  int tick_cnt = 0;
  logic tick_seen = 1'b0;

  localparam int P = 4;

  always #2 clk = ~clk;

  rs485_tx_guard u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode(mode),
    .parity_sel(parity_sel), .guard_len(guard_len), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .txd(txd), .tx_empty(tx_empty),
    .drv_en(drv_en)
  );

  always @(negedge clk) begin
    tick_cnt  <= (tick_cnt == P - 1) ? 0 : tick_cnt + 1;
    baud_tick <= (tick_cnt == P - 2);
  end
  always @(posedge clk) tick_seen <= baud_tick;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit drv_exp();
    return (mode == 2'b01);
  endfunction

  task automatic busy_checks(input string req);
    chk(tx_empty == 1'b0, {req, "/R7 tx_empty"}, tx_empty, 0);
    chk(drv_en == drv_exp(), {req, "/R8 drv_en"}, drv_en, drv_exp());
  endtask

  task automatic put(input logic [7:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R6 ready low while held", in_ready, 0);
    busy_checks("after accept");
  endtask

  // Called at 0.5 cycle into the start bit; returns 0.5 cycle into the bit after the last guard.
  task automatic frame(input logic [7:0] d, input bit have_next, input logic [7:0] d2);
    int wait0;
    chk(tick_seen == 1'b1, "R9 start on tick", tick_seen, 1);
    @(negedge clk);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    busy_checks("start");
    wait0 = P;
    if (have_next) begin
      chk(in_ready == 1'b1, "R6 ready after take", in_ready, 1);
      in_valid = 1'b1; in_data = d2;
      @(negedge clk);
      in_valid = 1'b0;
      chk(in_ready == 1'b0, "R6 ready low with byte held", in_ready, 0);
      in_valid = 1'b1; in_data = ~d2;
      @(negedge clk);
      in_valid = 1'b0;
      wait0 = P - 2;
    end
    for (int i = 0; i < 8; i++) begin
      repeat ((i == 0) ? wait0 : P) @(negedge clk);
      chk(txd == d[i], "R2 data bit", txd, d[i]);
      busy_checks("data");
    end
    if (parity_sel == 2'b01 || parity_sel == 2'b10) begin
      repeat (P) @(negedge clk);
      chk(txd == ((^d) ^ (parity_sel == 2'b10)), "R3 parity bit", txd,
          (^d) ^ (parity_sel == 2'b10));
      busy_checks("parity");
    end
    repeat (P) @(negedge clk);
    chk(txd == 1'b1, "R2 stop bit", txd, 1);
    busy_checks("stop");
    for (int g = 0; g < int'(guard_len); g++) begin
      repeat (P) @(negedge clk);
      chk(txd == 1'b1, "R4 guard idle high", txd, 1);
      busy_checks("R4 guard");
    end
    repeat (P - 1) @(negedge clk);
  endtask

  task automatic run_cfg(input logic [7:0] d, input logic [7:0] d2);
    int guard_cycles;
    put(d);
    guard_cycles = 0;
    while (txd !== 1'b0 && guard_cycles < 50) begin
      @(negedge clk);
      guard_cycles++;
    end
    chk(txd == 1'b0, "R2 start seen", txd, 0);
    frame(d, 1'b1, d2);
    chk(txd == 1'b0, guard_len == 0 ? "R5 back-to-back start" : "R4 start after guard", txd, 0);
    frame(d2, 1'b0, 8'h00);
    chk(tx_empty == 1'b1, guard_len == 0 ? "R5 empty after stop" : "R4 empty after guard",
        tx_empty, 1);
    chk(drv_en == 1'b0, "R8 drv_en off when empty", drv_en, 0);
    chk(txd == 1'b1, "R6 ignored write sent nothing", txd, 1);
    repeat (2 * P) @(negedge clk);
    chk(tx_empty == 1'b1 && txd == 1'b1, "R6 no extra char", txd, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    chk(tx_empty == 1'b1, "R1 reset tx_empty", tx_empty, 1);
    chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    chk(drv_en == 1'b0, "R1 reset drv_en", drv_en, 0);
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int gi = 0; gi < 4; gi++) begin
          mode       = 2'(m);
          parity_sel = 2'(p);
          guard_len  = (gi == 3) ? 8'd4 : 8'(gi);
          run_cfg(8'((m * 97 + p * 53 + gi * 29 + 1) & 255),
                  (p == 0 && gi == 0) ? 8'hFF : 8'((m * 41 + p * 71 + gi * 13) & 255));
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule